// File: doc/BRIEF.md
# Chained Match-Channel Timer Bank

This block provides eight compare channels, numbered 4 to 11, for a general-purpose timer. Each channel owns a 32-bit up-counter, a 32-bit compare value and a control word. The control word chooses which of eight tick-enable sources advances the counter. It also decides whether the channel compares against its own counter or against the counter that leads its group, whether the counter it compares against returns to zero on a hit, and whether the channel re-arms after a hit or fires only once. Channels 9 and 11 can also copy the counter of the channel just below them into a shared capture register when software reads their own counter.

Hits set one sticky bit per channel in bits 4 to 11 of a shared status word. Software clears these bits by writing 1 to them, and a single interrupt line stays high while any of them is set. The tick sources come in as one-cycle enables that are synchronous to the block clock. Software reaches every register over a simple 32-bit word bus with write and read strobes and a combinational read path.

Top module: `mtmr_match_bank`

## Requirements
- R1: After reset, every counter, compare value, control word, status bit and the capture register reads 0, and `irq` is low.
- R2: Control bits [2:0] pick tick source n (1..7), and the counter advances by one in each cycle where `src_tick[n]` is high. Source 0 means stopped: the counter holds its value and its channel raises no hit.
- R3: When control bit 7 is 0, channels 4–7 compare against counter 4, channels 8–9 against counter 8, and channels 10–11 against counter 10. The counter of a channel that is not a group leader advances only when bit 7 is 1. When bit 7 is 1, the channel compares against its own counter.
- R4: An armed channel hits when the counter it compares against advances to the channel's compare value. The hit sets status bit 4+(channel−4) at the next clock edge.
- R5: When control bit 3 is set and the channel hits, the counter it compares against loads 0 in place of the compare value.
- R6: When control bit 6 is set, the channel stays armed after a hit. When bit 6 is clear, the channel disarms after its first hit. Writing the compare value or the control word re-arms the channel.
- R7: Channels 4–7 keep control bits [7:0] and channels 8–11 keep bits [9:0]. Bits that are not kept read back as 0.
- R8: On channels 8–11, control bit 8 forces source 0 (stopped), whatever bits [2:0] hold.
- R9: A read of the counter of channel 9 or 11 while its control bit 9 is set copies the counter of channel 8 or 10 into the capture register at 0xBC. A read with bit 9 clear leaves the capture register unchanged.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hit in the same cycle as a clear of its bit wins. `irq` is high exactly while any status bit is set.
- R11: Byte addresses: counters at 0x40+4·(ch−4), compare values at 0x80+4·(ch−4), control words at 0xC0+4·(ch−4), status at 0x14, capture at 0xBC. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 7 | Tick enables for sources 1..7 (bit n = source n) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the capture side effect) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
A channel with a wrong arm flag or a wrong group selection shows up as a status bit that is set or missing at the edge right after the tick that reaches the compare value. That status bit is visible on the very next read. A counter that is wrongly cleared or wrongly held is seen on the next counter read: it reads 0 or a stale count where the tick history predicts a different value. A capture fault shows only through the capture register, so the bench reads that register right after a counter read that should have triggered a copy, and again after one that should not have. A fault in the interrupt path shows on `irq` in the cycle after a status write.

// File: rtl/mtmr_pkg.sv
// Package: shared constants and channel-topology helpers for the match bank.
// Assumes channel index k (0..7) stands for channel number k+4.
package mtmr_pkg;
    localparam int unsigned CH_COUNT = 8;   // number of match channels
    localparam int unsigned CH_FIRST = 4;   // status bit of local channel 0
    localparam int unsigned CTRL_W   = 10;  // widest control word
    localparam int unsigned SEL_W    = 3;   // tick-source select width

    // control bit positions
    localparam int unsigned CB_CLR   = 3;   // zero the compared counter on hit
    localparam int unsigned CB_PER   = 6;   // stay armed after a hit
    localparam int unsigned CB_OWN   = 7;   // compare against own counter
    localparam int unsigned CB_FORCE = 8;   // force source 0 (wide channels)
    localparam int unsigned CB_SNAP  = 9;   // capture on counter read (ch 9, 11)

    // Group leader whose counter a chained channel compares against.
    function automatic int unsigned group_base(input int unsigned k);
        if (k < 4)      return 0;
        else if (k < 6) return 4;
        else            return 6;
    endfunction

    // Channels 8..11 keep the wide control word.
    function automatic bit is_wide(input int unsigned k);
        return k >= 4;
    endfunction

    // Channels 9 and 11 may capture their neighbour's counter.
    function automatic bit has_snap(input int unsigned k);
        return (k == 5) || (k == 7);
    endfunction
endpackage

// File: rtl/mtmr_decode.sv
// Module: address decoder for the match bank.
// Turns a byte address into one-hot region hits. It holds no state, and the
// top gates the hits with the strobes. Assumes word-aligned addresses, since
// any other address matches nothing.
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CNT_BASE   = 'h40,
    parameter int unsigned MATCH_BASE = 'h80,
    parameter int unsigned CTRL_BASE  = 'hC0,
    parameter int unsigned STAT_ADDR  = 'h14
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [CH_COUNT-1:0] hit_cnt,
    output logic [CH_COUNT-1:0] hit_match,
    output logic [CH_COUNT-1:0] hit_ctrl,
    output logic                hit_status,
    output logic                hit_snap
);
    localparam int unsigned SNAP_ADDR = CTRL_BASE - 4;

    // one comparator per channel and region
    for (genvar k = 0; k < CH_COUNT; k++) begin : g_hit
        assign hit_cnt[k]   = (addr == ADDR_W'(CNT_BASE   + 4 * k));
        assign hit_match[k] = (addr == ADDR_W'(MATCH_BASE + 4 * k));
        assign hit_ctrl[k]  = (addr == ADDR_W'(CTRL_BASE  + 4 * k));
    end

    assign hit_status = (addr == ADDR_W'(STAT_ADDR));
    assign hit_snap   = (addr == ADDR_W'(SNAP_ADDR));
endmodule

// File: rtl/mtmr_chan.sv
// Module: one match channel.
// Holds the channel's counter, compare value, control word and arm flag.
// Works out from its own control whether its counter advances this cycle.
// It hits when the counter it compares against (chosen by the top) advances
// onto the compare value. Assumes the top forms ref_cnt/ref_inc from
// control bit 7 and raises clr_cnt only on a hit against this counter.
module mtmr_chan
    import mtmr_pkg::*;
#(
    parameter int unsigned CH_IDX  = 0,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:1]  src_tick,
    input  logic                wr_cnt,
    input  logic                wr_match,
    input  logic                wr_ctrl,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                clr_cnt,
    input  logic [DATA_W-1:0]   ref_cnt,
    input  logic                ref_inc,
    output logic [DATA_W-1:0]   cnt_o,
    output logic [DATA_W-1:0]   match_o,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic                inc_o,
    output logic                event_o
);
    localparam bit IS_BASE = (group_base(CH_IDX) == CH_IDX);
    localparam bit IS_WIDE = is_wide(CH_IDX);
    localparam logic [CTRL_W-1:0] CTRL_MASK = IS_WIDE ? CTRL_W'('h3FF) : CTRL_W'('h0FF);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q, match_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              armed_q;
    logic [NUM_SRC-1:0] tick_vec;
    logic [SEL_W-1:0]   sel;
    logic               src_on, runs;

    // source 0 never ticks; bit 8 forces it on wide channels
    always_comb begin
        tick_vec = {src_tick, 1'b0};
        sel      = (IS_WIDE && ctrl_q[CB_FORCE]) ? '0 : ctrl_q[SEL_W-1:0];
        src_on   = tick_vec[sel];
        runs     = IS_BASE || ctrl_q[CB_OWN];
    end

    assign inc_o   = runs && src_on && !wr_cnt;
    assign event_o = armed_q && ref_inc && ((ref_cnt + ONE) == match_q);

    // counter: a bus write wins, then clear-on-hit, then the tick
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_cnt)  cnt_q <= wdata;
        else if (clr_cnt) cnt_q <= '0;
        else if (inc_o)   cnt_q <= cnt_q + ONE;
    end

    // compare value and control word, written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_match) match_q <= wdata;
            if (wr_ctrl)  ctrl_q  <= wdata[CTRL_W-1:0] & CTRL_MASK;
        end
    end

    // arm flag: set by setup writes, dropped after a one-shot hit
    always_ff @(posedge clk) begin
        if (!rst_n)                          armed_q <= 1'b0;
        else if (wr_match || wr_ctrl)        armed_q <= 1'b1;
        else if (event_o && !ctrl_q[CB_PER]) armed_q <= 1'b0;
    end

    assign cnt_o   = cnt_q;
    assign match_o = match_q;
    assign ctrl_o  = ctrl_q;

    // R5: a clear request with no bus write leaves the counter at zero
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cnt && !wr_cnt) |=> (cnt_q == '0));
    // R2: a counter that neither advances nor is written or cleared holds
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_o && !wr_cnt && !clr_cnt) |=> $stable(cnt_q));
    // R6: a one-shot hit with no re-arm write is not followed by another
    assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !ctrl_q[CB_PER] && !wr_match && !wr_ctrl) |=> !event_o);
endmodule

// File: rtl/mtmr_status.sv
// Module: sticky hit status and the shared interrupt.
// One bit per channel. A hit sets its bit and a write of 1 clears it; in the
// same cycle the set wins. Assumes ev_i pulses last one cycle per hit.
module mtmr_status #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_i,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_mask,
    output logic [NCH-1:0] status_o,
    output logic           irq_o
);
    logic [NCH-1:0] status_q;

    // sticky bits: clear what is written, then add new hits
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~(clr_wr ? clr_mask : '0)) | ev_i;
    end

    assign status_o = status_q;
    assign irq_o    = |status_q;

    // R4: any hit raises the interrupt at the next edge
    assert_hit_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> irq_o);
    // R10: the interrupt only falls after a status clear write
    assert_drop_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(clr_wr));
endmodule

// File: rtl/mtmr_match_bank.sv
// Module: top of the eight-channel match bank.
// Routes bus strobes to the channels, chooses for each channel the counter it
// compares against (its own or its group leader's), gathers clear-on-hit
// requests per counter, keeps the capture register and drives read data.
// Assumes DATA_W is the bus width and the counter width.
module mtmr_match_bank
    import mtmr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:1] src_tick,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);
    localparam int unsigned STAT_PAD = DATA_W - CH_FIRST - CH_COUNT;

    logic [CH_COUNT-1:0] hit_cnt, hit_match, hit_ctrl;
    logic                hit_status, hit_snap;
    logic [DATA_W-1:0]   cnt     [CH_COUNT];
    logic [DATA_W-1:0]   match   [CH_COUNT];
    logic [CTRL_W-1:0]   ctrl    [CH_COUNT];
    logic [DATA_W-1:0]   ref_cnt [CH_COUNT];
    logic [CH_COUNT-1:0] inc, ref_inc, ev, clr;
    logic [CH_COUNT-1:0] status;
    logic [DATA_W-1:0]   snap_q;

    mtmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr       (bus_addr),
        .hit_cnt    (hit_cnt),
        .hit_match  (hit_match),
        .hit_ctrl   (hit_ctrl),
        .hit_status (hit_status),
        .hit_snap   (hit_snap)
    );

    for (genvar k = 0; k < CH_COUNT; k++) begin : g_ch
        mtmr_chan #(.CH_IDX(k), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .wr_cnt   (bus_wr && hit_cnt[k]),
            .wr_match (bus_wr && hit_match[k]),
            .wr_ctrl  (bus_wr && hit_ctrl[k]),
            .wdata    (bus_wdata),
            .clr_cnt  (clr[k]),
            .ref_cnt  (ref_cnt[k]),
            .ref_inc  (ref_inc[k]),
            .cnt_o    (cnt[k]),
            .match_o  (match[k]),
            .ctrl_o   (ctrl[k]),
            .inc_o    (inc[k]),
            .event_o  (ev[k])
        );
    end

    // compared counter for each channel: its own, or its group leader's
    always_comb begin
        for (int unsigned k = 0; k < CH_COUNT; k++) begin
            ref_cnt[k] = ctrl[k][CB_OWN] ? cnt[k] : cnt[group_base(k)];
            ref_inc[k] = ctrl[k][CB_OWN] ? inc[k] : inc[group_base(k)];
        end
    end

    // clear-on-hit requests, gathered per counter
    always_comb begin
        clr = '0;
        for (int unsigned k = 0; k < CH_COUNT; k++) begin
            for (int unsigned j = 0; j < CH_COUNT; j++) begin
                if (ev[k] && ctrl[k][CB_CLR] &&
                    ((ctrl[k][CB_OWN] && j == k) ||
                     (!ctrl[k][CB_OWN] && group_base(k) == j)))
                    clr[j] = 1'b1;
            end
        end
    end

    mtmr_status #(.NCH(CH_COUNT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .clr_wr   (bus_wr && hit_status),
        .clr_mask (bus_wdata[CH_FIRST+CH_COUNT-1:CH_FIRST]),
        .status_o (status),
        .irq_o    (irq)
    );

    // capture register: a read of a capture-enabled counter copies its neighbour
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else begin
            for (int unsigned k = 0; k < CH_COUNT; k++) begin
                if (has_snap(k) && bus_rd && hit_cnt[k] && ctrl[k][CB_SNAP])
                    snap_q <= cnt[(k == 0) ? 0 : k - 1];
            end
        end
    end

    // read data mux; unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        for (int unsigned k = 0; k < CH_COUNT; k++) begin
            if (hit_cnt[k])   bus_rdata = cnt[k];
            if (hit_match[k]) bus_rdata = match[k];
            if (hit_ctrl[k])  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl[k]};
        end
        if (hit_status) bus_rdata = {{STAT_PAD{1'b0}}, status, {CH_FIRST{1'b0}}};
        if (hit_snap)   bus_rdata = snap_q;
    end

    // R9: an enabled read of channel 9's counter captures channel 8's counter
    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_cnt[5] && ctrl[5][CB_SNAP]) |=> (snap_q == $past(cnt[4])));
endmodule

// File: tb/tb_mtmr_match_bank.sv
`timescale 1ns/1ps
module tb_mtmr_match_bank;
    localparam int NV = 61;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2;

    typedef struct packed {
        logic [1:0]  op;    // write, read-and-compare, tick
        logic [7:0]  addr;  // address, or repeat count for a tick
        logic [31:0] data;  // write data, or source mask for a tick
        logic [31:0] exp;   // expected read data
        logic [7:0]  req;   // requirement number for the message
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{OP_W, 8'hC0, 32'h1,   32'h0,   8'd0},  // ch4 on source 1
        '{OP_W, 8'h80, 32'h3,   32'h0,   8'd0},
        '{OP_T, 8'd3,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h40, 32'h0,   32'h3,   8'd2},  // R2 counts source 1
        '{OP_R, 8'h14, 32'h0,   32'h10,  8'd4},  // R4 status bit 4
        '{OP_W, 8'h14, 32'h10,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h0,   8'd10}, // R10 write-1 clears
        '{OP_W, 8'hC0, 32'h49,  32'h0,   8'd0},  // periodic + clear-on-hit
        '{OP_W, 8'h40, 32'h0,   32'h0,   8'd0},
        '{OP_W, 8'h80, 32'h2,   32'h0,   8'd0},
        '{OP_T, 8'd2,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h40, 32'h0,   32'h0,   8'd5},  // R5 counter zeroed
        '{OP_R, 8'h14, 32'h0,   32'h10,  8'd4},
        '{OP_W, 8'h14, 32'h10,  32'h0,   8'd0},
        '{OP_T, 8'd2,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h10,  8'd6},  // R6 periodic hits again
        '{OP_R, 8'h40, 32'h0,   32'h0,   8'd5},
        '{OP_W, 8'hC0, 32'h09,  32'h0,   8'd0},  // one-shot + clear-on-hit
        '{OP_W, 8'h40, 32'h0,   32'h0,   8'd0},
        '{OP_W, 8'h14, 32'h10,  32'h0,   8'd0},
        '{OP_T, 8'd2,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h10,  8'd6},
        '{OP_W, 8'h14, 32'h10,  32'h0,   8'd0},
        '{OP_T, 8'd2,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h0,   8'd6},  // R6 one-shot stays quiet
        '{OP_R, 8'h40, 32'h0,   32'h2,   8'd6},
        '{OP_W, 8'hC4, 32'h0,   32'h0,   8'd0},  // ch5 chained on counter 4
        '{OP_W, 8'h84, 32'h5,   32'h0,   8'd0},
        '{OP_T, 8'd3,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h20,  8'd3},  // R3 chained hit
        '{OP_R, 8'h44, 32'h0,   32'h0,   8'd3},  // R3 own counter idle
        '{OP_W, 8'h14, 32'h20,  32'h0,   8'd0},
        '{OP_W, 8'hC4, 32'h81,  32'h0,   8'd0},  // ch5 on its own counter
        '{OP_T, 8'd4,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h0,   8'd3},
        '{OP_T, 8'd1,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h14, 32'h0,   32'h20,  8'd3},
        '{OP_R, 8'h44, 32'h0,   32'h5,   8'd3},
        '{OP_W, 8'h14, 32'h20,  32'h0,   8'd0},
        '{OP_W, 8'hD0, 32'h03,  32'h0,   8'd0},  // ch8 on source 3
        '{OP_W, 8'h90, 32'h2,   32'h0,   8'd0},
        '{OP_W, 8'h50, 32'h0,   32'h0,   8'd0},
        '{OP_T, 8'd2,  32'h02,  32'h0,   8'd0},
        '{OP_R, 8'h50, 32'h0,   32'h0,   8'd2},  // R2 other source ignored
        '{OP_T, 8'd2,  32'h08,  32'h0,   8'd0},
        '{OP_R, 8'h50, 32'h0,   32'h2,   8'd2},
        '{OP_R, 8'h14, 32'h0,   32'h100, 8'd4},
        '{OP_W, 8'h14, 32'h100, 32'h0,   8'd0},
        '{OP_W, 8'hD0, 32'h103, 32'h0,   8'd0},  // R8 bit 8 forces stop
        '{OP_T, 8'd2,  32'h08,  32'h0,   8'd0},
        '{OP_R, 8'h50, 32'h0,   32'h2,   8'd8},
        '{OP_W, 8'hD0, 32'h0,   32'h0,   8'd0},  // R2 source 0 stopped
        '{OP_T, 8'd3,  32'hFE,  32'h0,   8'd0},
        '{OP_R, 8'h50, 32'h0,   32'h2,   8'd2},
        '{OP_W, 8'hD4, 32'h200, 32'h0,   8'd0},  // R9 capture on ch9 read
        '{OP_R, 8'h54, 32'h0,   32'h0,   8'd9},
        '{OP_R, 8'hBC, 32'h0,   32'h2,   8'd9},
        '{OP_W, 8'h50, 32'h7,   32'h0,   8'd0},
        '{OP_W, 8'hD4, 32'h0,   32'h0,   8'd0},  // capture disabled
        '{OP_R, 8'h54, 32'h0,   32'h0,   8'd9},
        '{OP_R, 8'hBC, 32'h0,   32'h2,   8'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:1]  src_tick = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0, cyc = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    mtmr_match_bank dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 chk(req, bus_rdata, e);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_tick(input int n, input logic [7:0] m);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = m[7:1];
            @(posedge clk); #1;
            src_tick = '0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        do_rd(8'h40, 32'h0, 1);
        do_rd(8'h80, 32'h0, 1);
        do_rd(8'hC0, 32'h0, 1);
        do_rd(8'h14, 32'h0, 1);
        do_rd(8'hBC, 32'h0, 1);
        chk(1, {31'b0, irq}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_W:    do_wr(VEC[i].addr, VEC[i].data);
                OP_R:    do_rd(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                default: do_tick(int'(VEC[i].addr), VEC[i].data[7:0]);
            endcase
        end

        // R7: control width per channel class
        do_wr(8'hC0, 32'h3FF);
        do_rd(8'hC0, 32'hFF, 7);
        do_wr(8'hC0, 32'h0);
        do_wr(8'hD0, 32'hFFFF_FFFF);
        do_rd(8'hD0, 32'h3FF, 7);
        do_wr(8'hD0, 32'h0);

        // R11: unmapped addresses
        do_rd(8'h30, 32'h0, 11);
        do_wr(8'h30, 32'hFFFF_FFFF);
        do_rd(8'h14, 32'h0, 11);
        do_rd(8'h10, 32'h0, 11);

        // R10: shared interrupt with two channels pending
        do_wr(8'hD8, 32'h01); do_wr(8'h98, 32'h1); do_wr(8'h58, 32'h0);
        do_wr(8'hDC, 32'h81); do_wr(8'h9C, 32'h1); do_wr(8'h5C, 32'h0);
        do_tick(1, 8'h02);
        do_rd(8'h14, 32'hC00, 4);
        chk(10, {31'b0, irq}, 32'h1);
        do_wr(8'h14, 32'h400);
        #1 chk(10, {31'b0, irq}, 32'h1);
        do_wr(8'h14, 32'h800);
        #1 chk(10, {31'b0, irq}, 32'h0);

        // R10: a hit beats a clear in the same cycle
        do_wr(8'h98, 32'h2);
        @(negedge clk);
        src_tick = 7'b0000001; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h400;
        @(posedge clk); #1;
        src_tick = '0; bus_wr = 1'b0;
        do_rd(8'h14, 32'h400, 10);

        // R1: reset in mid-run
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        do_rd(8'h58, 32'h0, 1);
        do_rd(8'h14, 32'h0, 1);
        do_rd(8'hBC, 32'h0, 1);
        chk(1, {31'b0, irq}, 32'h0);

        finish_run();
    end
endmodule